// File: doc/BRIEF.md
# Six-Channel Shadowed PWM Generator

This block is a register-mapped pulse-width modulation peripheral with six channels that run independently. Each channel has a control word, a period count and a duty count, all measured in cycles of the block clock. Software writes new counts into shadow copies. Setting the commit bit in the control word marks them for transfer. The running waveform picks up the transfer only when the current period has ended, so a change never cuts a period short or stretches it.

A channel stays silent, with its output low and its counter at zero, until software writes the launch bit. After that the channel repeats its period without end. The polarity bit picks which part of each period the duty count covers: the leading high part, or the leading low part. To turn a running channel off, software commits a zero duty count with the polarity bit set, which gives a steady low output. Reads return the shadow contents at once, in the same cycle, with no wait.

Top module: `pwm_multichan`

## Requirements
- R1: Channel n occupies byte addresses n×0x20 upward. The control word is at +0x00, the period count at +0x08 and the duty count at +0x0C. A read of the period or duty address returns the last value written there. A read of a control word returns the last written value with every bit cleared except bit 0 (launch), bit 2 (commit), bit 5 (continuous) and bit 8 (polarity).
- R2: Addresses of 0xB0 and above, and the offsets inside a channel that R1 does not name, read as zero. Writes to them change no register.
- R3: After reset, and until a control write with bit 0 set reaches that channel, the channel's output is low.
- R4: A control write with bit 0 set starts the channel with its counter at 0 in the first cycle after the write. The counter then runs 0..P−1 and wraps, period after period. Later control writes with bit 0 clear do not stop the channel.
- R5: With the active polarity at 1, the output is high while the counter is below the active duty count D, and low for the rest of the period.
- R6: With the active polarity at 0, the output is low while the counter is below D, and high for the rest of the period.
- R7: Writing the period or duty count without a commit leaves the waveform unchanged.
- R8: For a running channel, a control write with bit 2 set loads the shadow period, duty and polarity into the active set at the end of the period that is running at the time of the write. The new waveform begins at counter 0.
- R9: A commit made before the channel is launched takes effect from the channel's very first period.
- R10: If D ≥ P, the duty phase lasts the whole period. A period count of 0 behaves as a period of 1.
- R11: A duty count of 0 with polarity 1 keeps the output low, and this turns a running channel off at the next boundary.
- R12: Starting or reconfiguring one channel leaves the outputs of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it also clocks the PWM counters |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address for the register read and the register write |
| busWrEn | input | 1 | Write strobe; the write is captured on the rising clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| pwmOut | output | 6 | One PWM output per channel |

## Verification
The checker watches four things on every cycle. An output stays low until its channel has been launched. Unmapped addresses read zero. A count register reads back what was just written to it. A control word reads back masked to its four defined bits. The bench's scenarios cover what needs a timeline: the waveform period by period under both polarities, a commit deferred to the period boundary rather than applied mid-period, a commit held before launch, a launch that survives later control writes with bit 0 clear, a zero period, a duty count larger than the period, a running channel turned off, and channels that do not disturb one another.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int unsigned PWM_CHANNELS = 6;
  localparam int unsigned CH_IDX_W = $clog2(PWM_CHANNELS);

  // control word bit positions
  localparam int unsigned BIT_LAUNCH = 0;
  localparam int unsigned BIT_COMMIT = 2;
  localparam int unsigned BIT_CONT   = 5;
  localparam int unsigned BIT_POL    = 8;

  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_PERIOD, SEL_DUTY} reg_sel_e;

  typedef struct packed {
    logic [PWM_CHANNELS-1:0] ctrlWr;
    logic [PWM_CHANNELS-1:0] periodWr;
    logic [PWM_CHANNELS-1:0] dutyWr;
    logic [CH_IDX_W-1:0]     rdChan;
    reg_sel_e                rdSel;
  } bus_strobe_t;
endpackage

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode
  import pwm_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned CH_STRIDE    = 32,
  parameter int unsigned WINDOW_BYTES = 176,
  parameter int unsigned OFF_CTRL     = 0,
  parameter int unsigned OFF_PERIOD   = 8,
  parameter int unsigned OFF_DUTY     = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output bus_strobe_t       strobe
);
  localparam int unsigned MAX_CHAN_IDX = (1 << ADDR_W) / CH_STRIDE;

  int unsigned chanIdx;
  int unsigned offset;
  logic        inWindow;
  reg_sel_e    sel;

  always_comb begin
    chanIdx  = int'(busAddr) / CH_STRIDE;
    offset   = int'(busAddr) % CH_STRIDE;
    inWindow = (int'(busAddr) < WINDOW_BYTES) && (chanIdx < PWM_CHANNELS)
               && (chanIdx < MAX_CHAN_IDX);
    if (!inWindow)                sel = SEL_NONE;
    else if (offset == OFF_CTRL)   sel = SEL_CTRL;
    else if (offset == OFF_PERIOD) sel = SEL_PERIOD;
    else if (offset == OFF_DUTY)   sel = SEL_DUTY;
    else                           sel = SEL_NONE;
  end

  always_comb begin
    strobe.rdSel  = sel;
    strobe.rdChan = CH_IDX_W'(chanIdx);
  end

  for (genvar ch = 0; ch < PWM_CHANNELS; ch++) begin : g_strobe
    logic hitChan;
    assign hitChan = busWrEn && (chanIdx == ch);
    assign strobe.ctrlWr[ch]   = hitChan && (sel == SEL_CTRL);
    assign strobe.periodWr[ch] = hitChan && (sel == SEL_PERIOD);
    assign strobe.dutyWr[ch]   = hitChan && (sel == SEL_DUTY);
  end
endmodule

// File: rtl/pwm_chan_bank.sv
module pwm_chan_bank
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bus_strobe_t             strobe,
  input  logic [DATA_W-1:0]       wrData,
  output logic [DATA_W-1:0]       rdData,
  output logic [PWM_CHANNELS-1:0] pwmOut
);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << BIT_LAUNCH) | (DATA_W'(1) << BIT_COMMIT) |
    (DATA_W'(1) << BIT_CONT)   | (DATA_W'(1) << BIT_POL);

  logic [DATA_W-1:0] ctrlView   [PWM_CHANNELS];
  logic [CNT_W-1:0]  periodView [PWM_CHANNELS];
  logic [CNT_W-1:0]  dutyView   [PWM_CHANNELS];

  for (genvar ch = 0; ch < PWM_CHANNELS; ch++) begin : g_chan
    logic [DATA_W-1:0] ctrlSh;
    logic [CNT_W-1:0]  periodSh, dutySh, periodAct, dutyAct, cnt, lastCnt;
    logic              polAct, pending, running, wrap, reload, inDuty;

    // a zero period behaves as a period of one clock
    assign lastCnt = (periodAct == '0) ? '0 : periodAct - CNT_W'(1);
    assign wrap    = running && (cnt >= lastCnt);
    assign reload  = pending && (!running || wrap);
    assign inDuty  = cnt < dutyAct;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlSh    <= '0;
        periodSh  <= '0;
        dutySh    <= '0;
        periodAct <= '0;
        dutyAct   <= '0;
        polAct    <= 1'b0;
        pending   <= 1'b0;
        running   <= 1'b0;
        cnt       <= '0;
      end else begin
        if (reload) begin
          periodAct <= periodSh;
          dutyAct   <= dutySh;
          polAct    <= ctrlSh[BIT_POL];
          pending   <= 1'b0;
        end
        if (strobe.periodWr[ch]) periodSh <= CNT_W'(wrData);
        if (strobe.dutyWr[ch])   dutySh   <= CNT_W'(wrData);
        if (strobe.ctrlWr[ch]) begin
          ctrlSh <= wrData & CTRL_MASK;
          if (wrData[BIT_COMMIT]) pending <= 1'b1;
          if (wrData[BIT_LAUNCH]) running <= 1'b1;
        end
        if (!running || wrap) cnt <= '0;
        else                  cnt <= cnt + CNT_W'(1);
      end
    end

    assign pwmOut[ch]     = running && (polAct ? inDuty : !inDuty);
    assign ctrlView[ch]   = ctrlSh;
    assign periodView[ch] = periodSh;
    assign dutyView[ch]   = dutySh;
  end

  always_comb begin
    rdData = '0;
    if (int'(strobe.rdChan) < PWM_CHANNELS) begin
      unique case (strobe.rdSel)
        SEL_CTRL:   rdData = ctrlView[strobe.rdChan];
        SEL_PERIOD: rdData = DATA_W'(periodView[strobe.rdChan]);
        SEL_DUTY:   rdData = DATA_W'(dutyView[strobe.rdChan]);
        default:    rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_multichan.sv
module pwm_multichan
  import pwm_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned CH_STRIDE    = 32,
  parameter int unsigned WINDOW_BYTES = 176
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrEn,
  input  logic [DATA_W-1:0]       busWrData,
  output logic [DATA_W-1:0]       busRdData,
  output logic [PWM_CHANNELS-1:0] pwmOut
);
  bus_strobe_t strobe;

  pwm_bus_decode #(
    .ADDR_W(ADDR_W), .CH_STRIDE(CH_STRIDE), .WINDOW_BYTES(WINDOW_BYTES)
  ) u_decode (
    .busAddr(busAddr), .busWrEn(busWrEn), .strobe(strobe)
  );

  pwm_chan_bank #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .rdData(busRdData), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_multichan_chk.sv
module pwm_multichan_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NCH    = 6,
  parameter int unsigned STRIDE = 32,
  parameter int unsigned WINDOW = 176
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [NCH-1:0]    pwmOut
);
  localparam logic [DATA_W-1:0] DEFINED_BITS = DATA_W'(32'h0000_0125);

  logic inWin, isCtrl, isCount, isMapped;
  int unsigned aChan, aOff;
  logic [NCH-1:0] launched;

  always_comb begin
    aChan    = int'(busAddr) / STRIDE;
    aOff     = int'(busAddr) % STRIDE;
    inWin    = (int'(busAddr) < WINDOW) && (aChan < NCH);
    isCtrl   = inWin && (aOff == 0);
    isCount  = inWin && ((aOff == 8) || (aOff == 12));
    isMapped = isCtrl || isCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) launched <= '0;
    else for (int ch = 0; ch < NCH; ch++)
      if (busWrEn && isCtrl && (aChan == ch) && busWrData[0]) launched[ch] <= 1'b1;
  end

  // R3
  prestart_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwmOut & ~launched) == '0);

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped |-> busRdData == '0);

  // R1
  count_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && isCount |=> (busAddr != $past(busAddr)) || (busRdData == $past(busWrData)));

  // R1
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && isCtrl |=> (busAddr != $past(busAddr)) ||
                          (busRdData == ($past(busWrData) & DEFINED_BITS)));
endmodule

bind pwm_multichan pwm_multichan_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(pwm_pkg::PWM_CHANNELS),
  .STRIDE(CH_STRIDE), .WINDOW(WINDOW_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .pwmOut(pwmOut)
);

// File: tb/pwm_multichan_bench.sv
module pwm_multichan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 6;
  localparam int TIMEOUT    = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [5:0]  pwmOut;

  int cyc = 0, nChecks = 0, nFails = 0, lastAt = 0;

  typedef struct { int at; logic val; string tag; } exp_t;
  exp_t expQ [NCH][$];

  pwm_multichan u_pwm_multichan (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic wrReg(int addr, logic [31:0] d);
    @(negedge clk);
    busAddr = addr[7:0]; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
    lastAt = cyc;
  endtask

  task automatic rdCheck(int addr, logic [31:0] expv, string req);
    @(negedge clk);
    busAddr = addr[7:0];
    #1;
    check(busRdData == expv, req, $sformatf("read 0x%0h", addr), busRdData, expv);
  endtask

  // expected waveform built from R4/R5/R6/R10
  task automatic expectSpan(int ch, int fromC, int toC, int startC, int per, int duty,
                            bit pol, string tag);
    int pe;
    pe = (per == 0) ? 1 : per;
    for (int c = fromC; c <= toC; c++) begin
      exp_t e;
      bit inD;
      inD = ((c - startC) % pe) < duty;
      e.at = c; e.val = pol ? inD : !inD; e.tag = tag;
      expQ[ch].push_back(e);
    end
  endtask

  // first cycle of the period following the commit (R8)
  function automatic int nextBoundary(int commitAt, int startC, int per);
    int c;
    c = commitAt;
    while (((c - startC) % per) != per - 1) c++;
    return c + 1;
  endfunction

  task automatic waitUntil(int c);
    while (cyc < c) @(posedge clk);
    #1;
  endtask

  task automatic waitIdle();
    bit busy;
    busy = 1'b1;
    while (busy) begin
      busy = 1'b0;
      for (int ch = 0; ch < NCH; ch++) if (expQ[ch].size() != 0) busy = 1'b1;
      if (busy) @(posedge clk);
    end
    @(negedge clk);
  endtask

  // monitor: pops expectations for the current cycle
  initial forever begin
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) begin
      while (expQ[ch].size() > 0 && expQ[ch][0].at <= cyc) begin
        exp_t e;
        e = expQ[ch].pop_front();
        if (e.at < cyc) check(1'b0, e.tag, "missed sample", cyc, e.at);
        else check(pwmOut[ch] === e.val, e.tag,
                   $sformatf("ch%0d out at cycle %0d", ch, cyc), pwmOut[ch], e.val);
      end
    end
  end

  initial begin
    while (cyc < TIMEOUT) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R4 watchdog expired: actual cycle %0d expected below %0d", cyc, TIMEOUT);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int s0, s2, s1, s3, hz, hz2, cA, nb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R3: reset state
    check(pwmOut == 6'b0, "R3", "outputs after reset", pwmOut, 0);
    rdCheck(32'h00, 32'h0, "R3");
    for (int ch = 0; ch < NCH; ch++) expectSpan(ch, cyc + 1, cyc + 6, 0, 1, 1, 0, "R3");

    // R1: register map and readback
    wrReg(32'h08, 32'd5);
    wrReg(32'h0C, 32'd2);
    rdCheck(32'h08, 32'd5, "R1");
    rdCheck(32'h0C, 32'd2, "R1");
    wrReg(32'h20, 32'hFFFF_FFFE);
    rdCheck(32'h20, 32'h0000_0124, "R1");
    wrReg(32'hA8, 32'd9);
    rdCheck(32'hA8, 32'd9, "R1");

    // R2: unmapped space
    wrReg(32'h04, 32'hDEAD_BEEF);
    rdCheck(32'h04, 32'h0, "R2");
    wrReg(32'hB0, 32'h77);
    rdCheck(32'hB0, 32'h0, "R2");
    rdCheck(32'hC8, 32'h0, "R2");
    rdCheck(32'h08, 32'd5, "R2");
    rdCheck(32'h0C, 32'd2, "R2");

    // R9/R3: commit before launch keeps output low
    wrReg(32'h00, 32'h124);
    expectSpan(0, lastAt + 1, lastAt + 8, 0, 1, 1, 0, "R3");
    waitIdle();

    // R9/R5/R4: launch ch0, P=5 D=2 polarity 1
    wrReg(32'h00, 32'h121);
    s0 = lastAt;
    expectSpan(0, s0, s0 + 4, s0, 5, 2, 1, "R9");
    expectSpan(0, s0 + 5, s0 + 9, s0, 5, 2, 1, "R5");
    wrReg(32'h00, 32'h120);
    expectSpan(0, s0 + 10, s0 + 14, s0, 5, 2, 1, "R4");
    // R7: shadow writes without commit
    wrReg(32'h08, 32'd8);
    wrReg(32'h0C, 32'd6);
    expectSpan(0, s0 + 15, s0 + 19, s0, 5, 2, 1, "R7");
    hz = s0 + 19;
    // R8: commit applied at the period boundary
    waitUntil(hz - 2);
    wrReg(32'h00, 32'h124);
    cA = lastAt;
    nb = nextBoundary(cA, s0, 5);
    if (nb - 1 > hz) expectSpan(0, hz + 1, nb - 1, s0, 5, 2, 1, "R8");
    expectSpan(0, nb, nb + 79, nb, 8, 6, 1, "R8");

    // R6/R12: ch2 with polarity 0 while ch0 runs; ch3 untouched
    wrReg(32'h48, 32'd4);
    wrReg(32'h4C, 32'd1);
    wrReg(32'h40, 32'h024);
    wrReg(32'h40, 32'h021);
    s2 = lastAt;
    expectSpan(2, s2, s2 + 15, s2, 4, 1, 0, "R6");
    expectSpan(3, s2, s2 + 15, 0, 1, 1, 0, "R12");
    hz2 = s2 + 15;
    // R11: turn ch2 off with duty 0 and polarity 1
    wrReg(32'h4C, 32'd0);
    waitUntil(hz2 - 2);
    wrReg(32'h40, 32'h124);
    cA = lastAt;
    nb = nextBoundary(cA, s2, 4);
    if (nb - 1 > hz2) expectSpan(2, hz2 + 1, nb - 1, s2, 4, 1, 0, "R11");
    expectSpan(2, nb, nb + 11, nb, 4, 0, 1, "R11");
    waitIdle();

    // R10: duty beyond period, and zero period
    wrReg(32'h28, 32'd3);
    wrReg(32'h2C, 32'd7);
    wrReg(32'h20, 32'h124);
    wrReg(32'h20, 32'h121);
    s1 = lastAt;
    expectSpan(1, s1, s1 + 11, s1, 3, 7, 1, "R10");
    wrReg(32'h68, 32'd0);
    wrReg(32'h6C, 32'd1);
    wrReg(32'h60, 32'h124);
    wrReg(32'h60, 32'h121);
    s3 = lastAt;
    expectSpan(3, s3, s3 + 11, s3, 0, 1, 1, "R10");
    waitIdle();

    // R3/R12: ch5 never launched
    check(pwmOut[5] == 1'b0, "R12", "ch5 idle", pwmOut[5], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule